// File: doc/BRIEF.md
# LMS Adaptive Noise Canceller

This block removes a noise component from a signal when a separate copy of that noise is available. Each sample arrives as one 32-bit stereo word. The lower signed 16-bit half carries the wanted signal. The upper signed 16-bit half carries a reference noise that is correlated with the noise to be removed. Inside the block, the two halves are added to form the corrupted primary input. The reference half feeds a 30-tap adaptive FIR filter. The filter output is subtracted from the primary input, and the difference drives a least-mean-square update of every tap weight.

All arithmetic is fixed point. Weights are signed Q1.30 and the accumulator is 48 bits wide. The step size is an arithmetic right shift chosen per sample. A single multiplier serves every tap: first for the filter sum, then for the weight updates.

The caller pulses `start` with a sample and waits for `done`. A select input picks the 16-bit result: either the cancelled error or the uncancelled sum.

Top module: `lms_canceller`

## Requirements
- R1: After reset, `dout`, `done` and `busy` are 0, and all weights and delay taps are zero, so the first error result equals the saturated primary sum.
- R2: `smp_in[15:0]` is the signed wanted channel and `smp_in[31:16]` is the signed reference channel. The primary sum is wanted plus reference, saturated to [-32768, 32767] when output.
- R3: `raw_sel` is captured at the accepted `start`. A value of 0 outputs the cancelled error and 1 outputs the saturated primary sum.
- R4: The filter output is y = (sum over 30 taps of weight × tap sample, wrapped to 48 bits) arithmetically shifted right by 30. The error is the primary sum minus y, saturated to signed 16 bits.
- R5: After the error is formed, each weight w[i] becomes w[i] + ((e × x[i]) >>> shift), wrapped to 32 bits. Here e is the saturated error and x[i] is the tap sample before the shift. Weights change at no other time.
- R6: On acceptance, tap 0 takes the reference sample. After the updates, every tap moves one place older and the sample in tap 29 is dropped.
- R7: `done` is high for exactly one cycle. It rises 62 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises.
- R8: A `start` seen while `busy` is high is ignored. It does not change the result, the timing or the state.
- R9: `mu_shift` (0 to 31) is captured at the accepted `start` and sets the update shift for that sample.
- R10: `dout` changes only on the edge that raises `done`, and it holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample strobe, accepted only when idle |
| smp_in | input | 32 | Packed sample: reference in the upper half, wanted in the lower half |
| raw_sel | input | 1 | Output choice: 0 = error, 1 = primary sum |
| mu_shift | input | 5 | Step-size right-shift amount |
| dout | output | 16 | Signed result |
| done | output | 1 | One-cycle pulse when `dout` is new |
| busy | output | 1 | High while a sample is being processed |

## Verification
Each result is due 62 clock edges after the edge that accepts `start`. The bench counts falling edges from acceptance until `done` is seen, checks that the count is exactly 62, and only then compares `dout` with its own fixed-point model. Samples are taken on falling edges, away from the active edge. The bench also pokes `start` mid-run and one edge before completion; for those, it expects the same timing and the same result. After each result, it watches several further cycles to confirm that `dout` holds and `done` stays low.

// File: rtl/lms_pkg.sv
package lms_pkg;

    localparam int SMP_W  = 16;
    localparam int WGT_W  = 32;
    localparam int ACC_W  = 48;
    localparam int FRAC_B = 30;
    localparam int SH_W   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC,
        ST_ERR,
        ST_UPD,
        ST_SHF
    } lms_state_e;

    typedef struct packed {
        logic signed [SMP_W-1:0] ref_n;
        logic signed [SMP_W-1:0] want;
    } stereo_t;

    // clamp a wide signed value into the sample range
    function automatic logic signed [SMP_W-1:0] sat_smp(input logic signed [ACC_W:0] v);
        logic [ACC_W-SMP_W+1:0] top;
        top = v[ACC_W:SMP_W-1];
        if (&top || ~|top)
            return v[SMP_W-1:0];
        else if (v[ACC_W])
            return {1'b1, {(SMP_W-1){1'b0}}};
        else
            return {1'b0, {(SMP_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/lms_seq.sv
module lms_seq
    import lms_pkg::*;
#(
    parameter int NTAP  = 30,
    parameter int IDX_W = $clog2(NTAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output lms_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             accept
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NTAP - 1);

    assign accept = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (start) state <= ST_ACC;
                end
                ST_ACC: begin
                    if (idx == LAST) begin
                        idx   <= '0;
                        state <= ST_ERR;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_ERR: state <= ST_UPD;
                ST_UPD: begin
                    if (idx == LAST) begin
                        idx   <= '0;
                        state <= ST_SHF;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SHF: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(idx) < NTAP);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (state == ST_ACC || state == ST_UPD)) |=> (state != ST_IDLE));

endmodule

// File: rtl/lms_taps.sv
module lms_taps
    import lms_pkg::*;
#(
    parameter int NTAP  = 30,
    parameter int IDX_W = $clog2(NTAP)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic signed [SMP_W-1:0] ref_in,
    input  logic                    shift_en,
    input  logic                    upd_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic signed [WGT_W-1:0] delta,
    output logic signed [WGT_W-1:0] w_rd,
    output logic signed [SMP_W-1:0] x_rd
);

    logic signed [WGT_W-1:0] wgt [NTAP];
    logic signed [SMP_W-1:0] xd  [NTAP];
    logic [NTAP-1:0]         hit;

    for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
        assign hit[gi] = upd_en && (idx == IDX_W'(gi));

        // R5
        wgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !hit[gi] |=> $stable(wgt[gi]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAP; i++) begin
                wgt[i] <= '0;
                xd[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NTAP; i++)
                if (hit[i]) wgt[i] <= wgt[i] + delta;
            if (load) xd[0] <= ref_in;
            if (shift_en)
                for (int i = 1; i < NTAP; i++)
                    xd[i] <= xd[i-1];
        end
    end

    assign w_rd = wgt[idx];
    assign x_rd = xd[idx];

endmodule

// File: rtl/lms_canceller.sv
module lms_canceller
    import lms_pkg::*;
#(
    parameter int NTAP  = 30,
    parameter int IDX_W = $clog2(NTAP)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [2*SMP_W-1:0]      smp_in,
    input  logic                    raw_sel,
    input  logic [SH_W-1:0]         mu_shift,
    output logic signed [SMP_W-1:0] dout,
    output logic                    done,
    output logic                    busy
);

    lms_state_e              state;
    logic [IDX_W-1:0]        idx;
    logic                    accept;
    stereo_t                 smp;
    logic signed [SMP_W:0]   prim_q;
    logic                    sel_q;
    logic [SH_W-1:0]         sh_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [SMP_W-1:0] err_q;
    logic signed [WGT_W-1:0] w_rd, mul_a, delta;
    logic signed [SMP_W-1:0] x_rd;
    logic signed [ACC_W-1:0] ma_x, mx_x, prod, prod_sh, acc_sh;
    logic signed [ACC_W:0]   prim_x, y_x, err_w;

    assign smp  = stereo_t'(smp_in);
    assign busy = (state != ST_IDLE);

    lms_seq #(.NTAP(NTAP), .IDX_W(IDX_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .state  (state),
        .idx    (idx),
        .accept (accept)
    );

    lms_taps #(.NTAP(NTAP), .IDX_W(IDX_W)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .ref_in   (smp.ref_n),
        .shift_en (state == ST_SHF),
        .upd_en   (state == ST_UPD),
        .idx      (idx),
        .delta    (delta),
        .w_rd     (w_rd),
        .x_rd     (x_rd)
    );

    // shared multiplier: weight x tap while summing, error x tap while updating
    assign mul_a   = (state == ST_ACC) ? w_rd : {{(WGT_W-SMP_W){err_q[SMP_W-1]}}, err_q};
    assign ma_x    = {{(ACC_W-WGT_W){mul_a[WGT_W-1]}}, mul_a};
    assign mx_x    = {{(ACC_W-SMP_W){x_rd[SMP_W-1]}}, x_rd};
    assign prod    = ma_x * mx_x;
    assign prod_sh = prod >>> sh_q;
    assign delta   = prod_sh[WGT_W-1:0];

    assign acc_sh  = acc_q >>> FRAC_B;
    assign y_x     = {acc_sh[ACC_W-1], acc_sh};
    assign prim_x  = {{(ACC_W-SMP_W){prim_q[SMP_W]}}, prim_q};
    assign err_w   = prim_x - y_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            sel_q  <= 1'b0;
            sh_q   <= '0;
            acc_q  <= '0;
            err_q  <= '0;
            dout   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                prim_q <= {smp.want[SMP_W-1], smp.want} + {smp.ref_n[SMP_W-1], smp.ref_n};
                sel_q  <= raw_sel;
                sh_q   <= mu_shift;
                acc_q  <= '0;
            end
            if (state == ST_ACC) acc_q <= acc_q + prod;
            if (state == ST_ERR) err_q <= sat_smp(err_w);
            if (state == ST_SHF) begin
                dout <= sel_q ? sat_smp(prim_x) : err_q;
                done <= 1'b1;
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> done);

endmodule

// File: tb/sim_lms_canceller.sv
module sim_lms_canceller;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [31:0]        smp_in = '0;
    logic               raw_sel = 1'b0;
    logic [4:0]         mu_shift = '0;
    logic signed [15:0] dout;
    logic               done;
    logic               busy;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int mw [30];
    int mx [30];

    always #10 clk = ~clk;

    lms_canceller u0 (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .smp_in   (smp_in),
        .raw_sel  (raw_sel),
        .mu_shift (mu_shift),
        .dout     (dout),
        .done     (done),
        .busy     (busy)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic model_step(input logic [31:0] word, input bit m, input int sh, output int expo);
        int     wl, rr, p, e;
        longint acc, y;
        wl = int'($signed(word[15:0]));
        rr = int'($signed(word[31:16]));
        p  = wl + rr;
        mx[0] = rr;
        acc = 0;
        for (int i = 0; i < 30; i++) acc += longint'(mw[i]) * longint'(mx[i]);
        acc = (acc <<< 16) >>> 16;
        y = acc >>> 30;
        e = sat16(longint'(p) - y);
        for (int i = 0; i < 30; i++) mw[i] = mw[i] + ((e * mx[i]) >>> sh);
        for (int i = 29; i >= 1; i--) mx[i] = mx[i-1];
        expo = m ? sat16(longint'(p)) : e;
    endtask

    task automatic run_sample(input logic [31:0] word, input bit m, input int sh,
                              input bit poke, input string tag);
        int k, expo;
        model_step(word, m, sh, expo);
        @(negedge clk);
        smp_in = word; raw_sel = m; mu_shift = sh[4:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; smp_in = $urandom; raw_sel = ~m; mu_shift = 5'($urandom);
        k = 0;
        while (!done) begin
            if (poke && (k == 10 || k == 61)) begin
                check("R8 busy during poke", longint'(busy), 1);
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        check({"R7 latency ", tag}, k, 62);
        check(tag, longint'(dout), longint'(expo));
        if (poke) begin
            @(negedge clk);
            check("R8 no restart after poke", longint'(busy), 0);
        end
    endtask

    task automatic hold_check();
        logic signed [15:0] held;
        held = dout;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10 dout hold", longint'(dout), longint'(held));
            check("R7 done single", longint'(done), 0);
        end
    endtask

    initial begin
        int expo;
        void'($urandom(32'd4242));
        for (int i = 0; i < 30; i++) begin mw[i] = 0; mx[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 dout reset", longint'(dout), 0);
        check("R1 done reset", longint'(done), 0);
        check("R1 busy reset", longint'(busy), 0);

        // R1 R2: zero weights give error = want + ref
        run_sample({16'sd100, 16'sd200}, 1'b0, 10, 1'b0, "R1 R2 first error");
        check("R1 literal first error", longint'(dout), 300);
        hold_check();

        // R2 R3: saturation of the primary sum
        run_sample({16'sh7fff, 16'sh7fff}, 1'b1, 12, 1'b0, "R2 R3 sat high");
        check("R2 literal sat high", longint'(dout), 32767);
        run_sample({16'sh8000, 16'sh8000}, 1'b1, 12, 1'b0, "R2 R3 sat low");
        check("R2 literal sat low", longint'(dout), -32768);
        run_sample({16'sd1000, 16'sd50}, 1'b1, 12, 1'b0, "R3 raw sum");
        run_sample({16'sd1000, 16'sd50}, 1'b0, 12, 1'b0, "R3 error");

        // R9: extreme shifts
        for (int i = 0; i < 6; i++)
            run_sample($urandom, 1'b0, 31, 1'b0, "R9 shift 31");
        for (int i = 0; i < 6; i++)
            run_sample({16'($urandom_range(0, 4000) - 2000), 16'($urandom)}, 1'b0, 0, 1'b0, "R9 shift 0");

        // R8: start pokes while busy
        run_sample($urandom, 1'b0, 14, 1'b1, "R8 poke result");
        run_sample($urandom, 1'b1, 14, 1'b1, "R8 poke raw");
        hold_check();

        // R4 R5 R6: correlated noise, adaptation tracked against the model
        for (int n = 0; n < 200; n++) begin
            logic [15:0] nz, wv;
            nz = 16'((n % 7) * 3000 - 9000);
            wv = 16'($urandom_range(0, 800) - 400);
            run_sample({nz, 16'(wv + 16'((n % 7) * 1500 - 4500))}, 1'b0, 18, 1'b0, "R4 R5 R6 adapt");
        end

        // R4 R5 R6 R3 R9: random mix
        for (int n = 0; n < 120; n++)
            run_sample($urandom, 1'($urandom), int'($urandom_range(6, 31)), (n % 17) == 0, "R4 R5 R6 random");
        hold_check();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule